// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Reader

This block fetches a run of consecutive bytes from a serial EEPROM. It drives the EEPROM through a single control word made of five signals: an access-high enable, an access-low enable, a serial clock, a data-out line and a data-in line. The host presents a 16-bit start offset, a byte count and a step-hold length, then pulses start for one cycle. The block opens access in two ordered steps. It clocks out the read opcode and the two address bytes and clocks in the requested bytes. It hands each byte over a valid/ready stream, closes access in two ordered steps and signals done.

Every change of the control word is held for a programmable number of system clocks, so the serial clock can be slowed to the EEPROM's timing. When the consumer is not ready, bit clocking pauses with the serial clock held low. A start request that arrives while a transfer is running is rejected with an error pulse and does not disturb that transfer.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, acc_hi_o=0, acc_lo_o=1, sclk_o=0, sdo_o=0, and rd_valid_o, busy_o, done_o and error_o are all 0.
- R2: Access is opened by first raising acc_hi_o while acc_lo_o stays 1, and only in a later step lowering acc_lo_o. The pair (acc_hi_o, acc_lo_o) never goes from (0,1) straight to (1,0) and is never (0,0).
- R3: Access is closed after every transfer by first raising acc_lo_o while acc_hi_o stays 1, and only in a later step lowering acc_hi_o. The block then rests with acc_hi_o=0 and acc_lo_o=1.
- R4: Each output bit is placed on sdo_o while sclk_o is low, then sclk_o rises, then it falls. sdo_o does not change while sclk_o is high, and sclk_o is high only while access is open (acc_hi_o=1, acc_lo_o=0).
- R5: Each input bit takes one sclk_o pulse, and sdi_i is sampled in the last system cycle of the high phase. A transfer of N bytes produces exactly 24 + 8N rising edges of sclk_o.
- R6: The first 24 bits shifted out, MSB first, are the opcode 0x03, then offset_i[15:8], then offset_i[7:0].
- R7: The N requested bytes appear on rd_data_o in address order, each assembled MSB first from sdi_i. Each byte is held with rd_valid_o=1 until a cycle with rd_ready_i=1.
- R8: Each control-word state lasts max(hold_i, 1) system clocks, using the hold_i value captured when start is accepted.
- R9: With count_i=0, the opcode and address are sent, access is closed, done_o pulses, and rd_valid_o never rises.
- R10: While rd_valid_o=1 and rd_ready_i=0, sclk_o stays low, rd_valid_o stays 1 and rd_data_o is stable.
- R11: done_o pulses for exactly one cycle after access has closed, and busy_o is 0 in the following cycle.
- R12: start_i asserted while busy_o=1 gives a one-cycle error_o pulse in the next cycle. It leaves the running transfer's offset, count and hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| offset_i | input | 16 | EEPROM start address, captured on start |
| count_i | input | CNT_W | Number of bytes to read, captured on start |
| hold_i | input | HOLD_W | System clocks per control-word state (0 acts as 1) |
| rd_ready_i | input | 1 | Consumer accepts the presented byte |
| sdi_i | input | 1 | Serial data from the EEPROM |
| acc_hi_o | output | 1 | Access-high enable of the control word |
| acc_lo_o | output | 1 | Access-low enable of the control word |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the EEPROM |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a byte awaiting acceptance |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| error_o | output | 1 | One-cycle pulse for a start rejected while busy |

## Verification
A new start request can land in the same cycles in which a running transfer is shifting out its address. The rejection logic and the sequencer's own progress then act together. The bench provokes this by pulsing start partway through the header, with a different offset and a longer hold. It judges the result by the single error pulse, by the header and data still matching the first offset, and by the serial-clock high width still matching the first hold.

// File: rtl/serial_rom_rd_pkg.sv
// Shared constants and the sequencer state type for the serial EEPROM reader.
// Assumes a single-opcode read with two address bytes sent MSB first.
package serial_rom_rd_pkg;
    localparam int            BYTE_W      = 8;
    localparam int            HDR_BYTES   = 3;
    localparam logic [7:0]    READ_OPCODE = 8'h03;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN_HI,
        ST_OPEN_LO,
        ST_OB_SET,
        ST_OB_RISE,
        ST_OB_FALL,
        ST_IB_RISE,
        ST_IB_FALL,
        ST_PUSH,
        ST_SHUT_LO,
        ST_SHUT_HI,
        ST_FIN
    } rd_state_e;
endpackage

// File: rtl/serial_rom_rd_timer.sv
// Step timer: measures how long each control-word state is held.
// Assumes restart_i pulses in the cycle the sequencer changes state; the hold
// length is captured on capture_i and zero is promoted to one.
module serial_rom_rd_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic              restart_i,
    input  logic              run_i,
    output logic              step_end_o
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_eff;
    logic [HOLD_W-1:0] load_val;

    // Promote a zero hold request and select captured or fresh length.
    always_comb begin
        hold_eff = (hold_i == '0) ? ONE : hold_i;
        load_val = capture_i ? hold_eff : hold_q;
    end

    // Capture the hold length when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= ONE;
        else if (capture_i) hold_q <= hold_eff;
    end

    // Count down the cycles left in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (restart_i)    cnt_q <= load_val - ONE;
        else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    assign step_end_o = run_i && (cnt_q == '0);

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/serial_rom_rd_shifter.sv
// Byte shifter pair: an outbound register presenting its MSB, and an inbound
// register filled MSB first. Assumes load and shift are never asserted together.
module serial_rom_rd_shifter
    import serial_rom_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_byte_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              sdi_i,
    output logic              tx_msb_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;

    // Outbound byte: load a new byte or move the next bit into the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (load_i)  tx_q <= load_byte_i;
        else if (shift_i) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
    end

    // Inbound byte: append the sampled bit at the LSB end.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (sample_i) rx_q <= {rx_q[BYTE_W-2:0], sdi_i};
    end

    assign tx_msb_o  = tx_q[BYTE_W-1];
    assign rx_byte_o = rx_q;

    // R7
    rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(rx_q));
endmodule

// File: rtl/serial_rom_rd_ctrl.sv
// Sequencer for the bit-banged read: open access, send opcode and address,
// clock in bytes with stream back-pressure, close access, report done.
// Assumes step_end_i comes from the step timer driven by timer_* outputs.
module serial_rom_rd_ctrl
    import serial_rom_rd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       offset_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_end_i,
    input  logic              rd_ready_i,
    input  logic              tx_msb_i,
    output logic              timer_run_o,
    output logic              timer_restart_o,
    output logic              hold_capture_o,
    output logic              tx_load_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              tx_shift_o,
    output logic              rx_sample_o,
    output logic              acc_hi_o,
    output logic              acc_lo_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    localparam int            BIT_W    = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [1:0]    HDR_LAST = 2'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    rd_state_e        state_q, state_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [1:0]       hdr_q, hdr_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [15:0]      off_q;
    logic             err_q;

    // Next-state and datapath control decode.
    always_comb begin
        state_d        = state_q;
        bit_d          = bit_q;
        hdr_d          = hdr_q;
        left_d         = left_q;
        tx_load_o      = 1'b0;
        tx_byte_o      = READ_OPCODE;
        tx_shift_o     = 1'b0;
        rx_sample_o    = 1'b0;
        hold_capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d        = ST_OPEN_HI;
                tx_load_o      = 1'b1;
                bit_d          = '0;
                hdr_d          = '0;
                left_d         = count_i;
                hold_capture_o = 1'b1;
            end
            ST_OPEN_HI: if (step_end_i) state_d = ST_OPEN_LO;
            ST_OPEN_LO: if (step_end_i) state_d = ST_OB_SET;
            ST_OB_SET:  if (step_end_i) state_d = ST_OB_RISE;
            ST_OB_RISE: if (step_end_i) state_d = ST_OB_FALL;
            ST_OB_FALL: if (step_end_i) begin
                if (bit_q != LAST_BIT) begin
                    bit_d      = bit_q + BIT_W'(1);
                    tx_shift_o = 1'b1;
                    state_d    = ST_OB_SET;
                end else begin
                    bit_d = '0;
                    if (hdr_q != HDR_LAST) begin
                        hdr_d     = hdr_q + 2'd1;
                        tx_load_o = 1'b1;
                        tx_byte_o = (hdr_q == 2'd0) ? off_q[15:8] : off_q[7:0];
                        state_d   = ST_OB_SET;
                    end else begin
                        state_d = (left_q == '0) ? ST_SHUT_LO : ST_IB_RISE;
                    end
                end
            end
            ST_IB_RISE: if (step_end_i) begin
                rx_sample_o = 1'b1;
                state_d     = ST_IB_FALL;
            end
            ST_IB_FALL: if (step_end_i) begin
                if (bit_q != LAST_BIT) begin
                    bit_d   = bit_q + BIT_W'(1);
                    state_d = ST_IB_RISE;
                end else begin
                    bit_d   = '0;
                    state_d = ST_PUSH;
                end
            end
            ST_PUSH: if (rd_ready_i) begin
                left_d  = left_q - CNT_ONE;
                state_d = (left_q == CNT_ONE) ? ST_SHUT_LO : ST_IB_RISE;
            end
            ST_SHUT_LO: if (step_end_i) state_d = ST_SHUT_HI;
            ST_SHUT_HI: if (step_end_i) state_d = ST_FIN;
            ST_FIN:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            hdr_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            hdr_q   <= hdr_d;
            left_q  <= left_d;
        end
    end

    // Capture the start offset of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                           off_q <= '0;
        else if (start_i && state_q == ST_IDLE) off_q <= offset_i;
    end

    // Flag a start request that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= start_i && (state_q != ST_IDLE);
    end

    // Timer control: restart on every state change, idle in untimed states.
    always_comb begin
        timer_restart_o = (state_d != state_q);
        timer_run_o     = !(state_q inside {ST_IDLE, ST_PUSH, ST_FIN});
    end

    // Control word and status decode from the current state.
    always_comb begin
        acc_hi_o   = !(state_q inside {ST_IDLE, ST_SHUT_HI, ST_FIN});
        acc_lo_o   = state_q inside {ST_IDLE, ST_OPEN_HI, ST_SHUT_LO, ST_SHUT_HI, ST_FIN};
        sclk_o     = state_q inside {ST_OB_RISE, ST_IB_RISE};
        sdo_o      = (state_q inside {ST_OB_SET, ST_OB_RISE, ST_OB_FALL}) && tx_msb_i;
        rd_valid_o = (state_q == ST_PUSH);
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_FIN);
        error_o    = err_q;
    end

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OB_FALL && step_end_i && bit_q == LAST_BIT
         && hdr_q == HDR_LAST && left_q == '0) |=> (state_q == ST_SHUT_LO));
endmodule

// File: rtl/serial_rom_reader.sv
// Top of the serial EEPROM reader: ties the sequencer, step timer and byte
// shifter together. Assumes sdi_i is synchronous to clk.
module serial_rom_reader
    import serial_rom_rd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       offset_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic              rd_ready_i,
    input  logic              sdi_i,
    output logic              acc_hi_o,
    output logic              acc_lo_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    logic              step_end;
    logic              timer_run;
    logic              timer_restart;
    logic              hold_capture;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_shift;
    logic              rx_sample;
    logic              tx_msb;

    serial_rom_rd_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .offset_i        (offset_i),
        .count_i         (count_i),
        .step_end_i      (step_end),
        .rd_ready_i      (rd_ready_i),
        .tx_msb_i        (tx_msb),
        .timer_run_o     (timer_run),
        .timer_restart_o (timer_restart),
        .hold_capture_o  (hold_capture),
        .tx_load_o       (tx_load),
        .tx_byte_o       (tx_byte),
        .tx_shift_o      (tx_shift),
        .rx_sample_o     (rx_sample),
        .acc_hi_o        (acc_hi_o),
        .acc_lo_o        (acc_lo_o),
        .sclk_o          (sclk_o),
        .sdo_o           (sdo_o),
        .rd_valid_o      (rd_valid_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .error_o         (error_o)
    );

    serial_rom_rd_timer #(.HOLD_W(HOLD_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (hold_capture),
        .hold_i     (hold_i),
        .restart_i  (timer_restart),
        .run_i      (timer_run),
        .step_end_o (step_end)
    );

    serial_rom_rd_shifter i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tx_load),
        .load_byte_i (tx_byte),
        .shift_i     (tx_shift),
        .sample_i    (rx_sample),
        .sdi_i       (sdi_i),
        .tx_msb_o    (tx_msb),
        .rx_byte_o   (rd_data_o)
    );

    // R2
    open_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_lo_o) |-> (acc_hi_o && $past(acc_hi_o)));

    // R3
    close_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_hi_o) |-> (acc_lo_o && $past(acc_lo_o)));

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R4
    sclk_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (acc_hi_o && !acc_lo_o));

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && !sclk_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R12
    error_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> ($past(start_i) && $past(busy_o)));
endmodule

// File: tb/test_serial_rom_reader.sv
`timescale 1ns/1ps
module test_serial_rom_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] offset_i = '0;
    logic [15:0] count_i = '0;
    logic [7:0]  hold_i = '0;
    logic        rd_ready_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        acc_hi_o, acc_lo_o, sclk_o, sdo_o;
    logic [7:0]  rd_data_o;
    logic        rd_valid_o, busy_o, done_o, error_o;

    int vectors = 0;
    int fails = 0;

    // EEPROM model and protocol monitor state.
    logic        p_hi = 1'b0, p_lo = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_done = 1'b0;
    logic [23:0] hdr_sh = '0;
    logic [7:0]  got [64];
    int rise_cnt = 0, in_idx = 0, hi_len = 0, last_hi_len = 0, n_got = 0;
    int bad_open = 0, bad_close = 0, bad_sclk = 0, bad_sdo = 0, bad_stall = 0, bad_done = 0;
    int done_cnt = 0, err_cnt = 0;

    always #5 clk = ~clk;

    serial_rom_reader i_serial_rom_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
        .count_i(count_i), .hold_i(hold_i), .rd_ready_i(rd_ready_i), .sdi_i(sdi_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
        .done_o(done_o), .error_o(error_o)
    );

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ 8'h6B;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: sample outputs mid-cycle, model the EEPROM, count protocol faults.
    always @(negedge clk) begin
        logic [15:0] a;
        if (rst_n) begin
            if (p_hi == 1'b0 && p_lo == 1'b1 && acc_hi_o == 1'b1 && acc_lo_o == 1'b0) bad_open++;
            if (p_hi == 1'b1 && p_lo == 1'b0 && acc_hi_o == 1'b0 && acc_lo_o == 1'b1) bad_close++;
            if (acc_hi_o == 1'b0 && acc_lo_o == 1'b0) begin bad_open++; bad_close++; end
            if (p_hi && p_lo && acc_hi_o && !acc_lo_o) begin
                rise_cnt = 0; in_idx = 0; hdr_sh = '0;
            end
            if (sclk_o && !(acc_hi_o && !acc_lo_o)) bad_sclk++;
            if (sclk_o && p_sclk && sdo_o != p_sdo) bad_sdo++;
            if (sclk_o && !p_sclk) begin
                if (rise_cnt < 24) hdr_sh = {hdr_sh[22:0], sdo_o};
                rise_cnt++;
                hi_len = 1;
            end else if (sclk_o) hi_len++;
            if (!sclk_o && p_sclk) begin
                last_hi_len = hi_len;
                if (rise_cnt > 24) in_idx++;
            end
            if (rd_valid_o && !rd_ready_i && sclk_o) bad_stall++;
            if (rd_valid_o && rd_ready_i) begin
                if (n_got < 64) got[n_got] = rd_data_o;
                n_got++;
            end
            if (p_done && (done_o || busy_o)) bad_done++;
            if (done_o) done_cnt++;
            if (error_o) err_cnt++;
        end
        a = hdr_sh[15:0] + 16'(in_idx >> 3);
        sdi_i = (acc_hi_o && !acc_lo_o && rise_cnt >= 24) ? rom_byte(a)[7 - (in_idx % 8)] : 1'b0;
        p_hi = acc_hi_o; p_lo = acc_lo_o; p_sclk = sclk_o; p_sdo = sdo_o; p_done = done_o;
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        // R1 reset state
        chk("R1 acc_hi", 32'(acc_hi_o), 32'd0);
        chk("R1 acc_lo", 32'(acc_lo_o), 32'd1);
        chk("R1 sclk/sdo", 32'({sclk_o, sdo_o}), 32'd0);
        chk("R1 valid/busy/done/error", 32'({rd_valid_o, busy_o, done_o, error_o}), 32'd0);
    endtask

    // One read; stall delays the first acceptance; retry injects a rejected start.
    task automatic do_read(input logic [15:0] off, input int cnt, input int hold,
                           input int stall, input bit retry);
        int n0, d0, e0, bo0, bc0, bs0, bd0, bst0, bdn0, waited, vseen, exp_hi;
        n0 = n_got; d0 = done_cnt; e0 = err_cnt; bo0 = bad_open; bc0 = bad_close;
        bs0 = bad_sclk; bd0 = bad_sdo; bst0 = bad_stall; bdn0 = bad_done;
        waited = 0; vseen = 0;
        exp_hi = (hold == 0) ? 1 : hold;
        offset_i = off; count_i = 16'(cnt); hold_i = 8'(hold);
        rd_ready_i = (stall == 0); start_i = 1'b1;
        step();
        start_i = 1'b0;
        while (done_cnt == d0 && waited < 20000) begin
            if (retry && waited == 40) begin
                start_i = 1'b1; offset_i = ~off; hold_i = 8'(hold + 3);
            end else start_i = 1'b0;
            if (rd_valid_o) vseen++;
            rd_ready_i = (vseen > stall);
            step();
            waited++;
        end
        start_i = 1'b0;
        step(); step();
        chk("R11 done seen once", 32'(done_cnt - d0), 32'd1);
        chk("R11 done one cycle, busy low after", 32'(bad_done - bdn0), 32'd0);
        chk("R6 header bits", 32'(hdr_sh), {8'h0, 8'h03, off});
        chk("R5 rising edges", 32'(rise_cnt), 32'(24 + 8 * cnt));
        chk("R7 byte count", 32'(n_got - n0), 32'(cnt));
        for (int i = 0; i < cnt; i++)
            if (n0 + i < 64)
                chk("R5/R7 byte value", 32'(got[n0 + i]), 32'(rom_byte(off + 16'(i))));
        chk("R2 open order", 32'(bad_open - bo0), 32'd0);
        chk("R3 close order", 32'(bad_close - bc0), 32'd0);
        chk("R4 sclk only while open", 32'(bad_sclk - bs0), 32'd0);
        chk("R4 sdo stable while sclk high", 32'(bad_sdo - bd0), 32'd0);
        chk("R10 no clocking while stalled", 32'(bad_stall - bst0), 32'd0);
        chk("R8 sclk high width", 32'(last_hi_len), 32'(exp_hi));
        chk("R3 closed at rest", 32'({acc_hi_o, acc_lo_o, busy_o}), 32'b010);
        chk("R12 error pulses", 32'(err_cnt - e0), retry ? 32'd1 : 32'd0);
    endtask

    task automatic t_zero_count();
        int n0;
        n0 = n_got;
        // R9 count zero: header then close, no data
        do_read(16'hA55A, 0, 1, 0, 1'b0);
        chk("R9 no bytes returned", 32'(n_got - n0), 32'd0);
        chk("R9 only header clocks", 32'(rise_cnt), 32'd24);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        do_read(16'h1234, 4, 2, 0, 1'b0);   // R6 R7 R8 main read
        do_read(16'hFFFE, 3, 0, 0, 1'b0);   // R8 zero hold acts as one, address wrap
        t_zero_count();                     // R9
        do_read(16'h0100, 2, 1, 20, 1'b0);  // R10 back-pressure on first byte
        do_read(16'h0F0F, 3, 2, 3, 1'b1);   // R12 rejected start, hold kept
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule